// File: doc/BRIEF.md
# Scan-Loaded Burst Command Test Wrapper

This block sits between a test access point and a memory core and stands in for the core's wide command and result buses. With the mode pin low, every command flop and every result flop is part of one serial chain. A tester can then load a batch of memory commands through a single data pin and unload earlier results through another, at any convenient speed. While the chain shifts, every strobe to the core is held inactive by AND gating, so the core never sees a partly loaded command.

When the mode pin is raised, the wrapper replays the loaded slots to the core on consecutive clock edges. A slot can hold a read, a word write, a line write or an invalidate. The core's response to each slot is captured in parallel into that slot's result register after a fixed read latency. Slots whose valid bit is clear are skipped: they issue nothing and leave their result register as it was. Once the batch has run, further clocks in this mode change nothing. Lowering the mode pin again shifts the captured results out while the next batch shifts in. Only the clock and the mode pin need to work at full speed.

Top module: `scan_burst_wrapper`

## Requirements
- R1: While `par_mode` is low, each rising clock edge moves the whole chain by one bit. `scan_in` enters chain bit 0 and `scan_out` always shows the top chain bit. The chain is SLOTS command slots of 3+ADDR_W+DATA_W bits each (slot k at bit k*(3+ADDR_W+DATA_W)), followed above them by SLOTS result slots of DATA_W+2 bits each.
- R2: While `par_mode` is low, `core_rd_en`, `core_word_we`, `core_line_we` and `core_inval` are all low.
- R3: On the first rising edge after `par_mode` goes high, slot 0 is presented to the core, and slots 1 to SLOTS-1 follow on the next edges. The operation code gives exactly one strobe: 00 read, 01 word write, 10 line write, 11 invalidate. `core_addr` and `core_wdata` carry the slot's fields.
- R4: Command slot layout, LSB first: data (DATA_W bits), address (ADDR_W bits), operation (2 bits), valid (1 bit, MSB). The slot shifted in last is slot 0.
- R5: A slot whose valid bit is 0 raises no strobe in its cycle, and its result register keeps the value it held before the burst.
- R6: RD_LAT edges after a valid slot is issued, its result register loads {1, core_hit, core_rdata}: the done flag in the MSB, hit below it and data in the low DATA_W bits.
- R7: After all slots have issued, further cycles with `par_mode` high raise no strobe and leave all command and result registers unchanged. Command registers are never altered by a burst.
- R8: After the burst, lowering `par_mode` shifts the captured results out on `scan_out`, top bit first, while new chain contents shift in.
- R9: Reset clears every chain flop (so `scan_out` reads 0) and the burst sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both shifting and burst replay |
| rst_n | input | 1 | Active-low synchronous reset |
| par_mode | input | 1 | 0 = serial shift, 1 = burst replay and capture |
| scan_in | input | 1 | Serial chain input |
| scan_out | output | 1 | Serial chain output (top chain bit) |
| core_rd_en | output | 1 | Read strobe to the core |
| core_word_we | output | 1 | Word write enable to the core, gated off while shifting |
| core_line_we | output | 1 | Line write enable to the core, gated off while shifting |
| core_inval | output | 1 | Invalidate strobe to the core |
| core_addr | output | ADDR_W | Address of the slot being issued |
| core_wdata | output | DATA_W | Write data of the slot being issued |
| core_rdata | input | DATA_W | Core read data, RD_LAT cycles after issue |
| core_hit | input | 1 | Core hit flag, same timing as core_rdata |

## Verification
A sequencer counter that starts late or skips would show up as strobes whose address and data belong to the wrong slot, already on the first edge of the burst. A misrouted capture would show up in the unloaded result stream only at the next shift, in the wrong slot's position. A broken link in the chain, or a command register disturbed during the burst, corrupts every bit that travels through it and is visible in the very next unload. Write enables that leak during shifting would appear at the ports in the shift cycle itself.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

   typedef enum logic [1:0] {
      OP_READ = 2'b00,
      OP_WWR  = 2'b01,
      OP_LWR  = 2'b10,
      OP_INV  = 2'b11
   } sbw_op_e;

   function automatic int cmd_width(input int addr_w, input int data_w);
      return 3 + addr_w + data_w;
   endfunction

   function automatic int res_width(input int data_w);
      return data_w + 2;
   endfunction

endpackage

// File: rtl/sbw_cmd_bank.sv
module sbw_cmd_bank
   import sbw_pkg::*;
#(
   parameter int SLOTS  = 4,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      shift_en,
   input  logic                      ser_in,
   output logic                      ser_out,
   output logic [SLOTS*cmd_width(ADDR_W, DATA_W)-1:0] cmd_flat
);

   localparam int CW = cmd_width(ADDR_W, DATA_W);

   logic [CW-1:0] slot_q [SLOTS];
   logic [SLOTS:0] link;

   assign link[0] = ser_in;

   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_q[k] <= '0;
         end else if (shift_en) begin
            slot_q[k] <= {slot_q[k][CW-2:0], link[k]};
         end
      end
      assign link[k+1] = slot_q[k][CW-1];
      assign cmd_flat[k*CW +: CW] = slot_q[k];
   end

   assign ser_out = link[SLOTS];

endmodule

// File: rtl/sbw_res_bank.sv
module sbw_res_bank
   import sbw_pkg::*;
#(
   parameter int SLOTS  = 4,
   parameter int DATA_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 shift_en,
   input  logic                 ser_in,
   input  logic [SLOTS-1:0]     cap_en,
   input  logic                 cap_hit,
   input  logic [DATA_W-1:0]    cap_data,
   output logic                 ser_out,
   output logic [SLOTS*res_width(DATA_W)-1:0] res_flat
);

   localparam int RW = res_width(DATA_W);

   logic [RW-1:0] slot_q [SLOTS];
   logic [SLOTS:0] link;
   logic [RW-1:0] cap_word;

   assign link[0]  = ser_in;
   assign cap_word = {1'b1, cap_hit, cap_data};

   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_q[k] <= '0;
         end else if (shift_en) begin
            slot_q[k] <= {slot_q[k][RW-2:0], link[k]};
         end else if (cap_en[k]) begin
            slot_q[k] <= cap_word;
         end
      end
      assign link[k+1] = slot_q[k][RW-1];
      assign res_flat[k*RW +: RW] = slot_q[k];
   end

   assign ser_out = link[SLOTS];

endmodule

// File: rtl/sbw_issue_seq.sv
module sbw_issue_seq
   import sbw_pkg::*;
#(
   parameter int SLOTS  = 4,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int RD_LAT = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      par_mode,
   input  logic [SLOTS*cmd_width(ADDR_W, DATA_W)-1:0] cmd_flat,
   output logic                      core_rd_en,
   output logic                      core_word_we,
   output logic                      core_line_we,
   output logic                      core_inval,
   output logic [ADDR_W-1:0]         core_addr,
   output logic [DATA_W-1:0]         core_wdata,
   output logic [SLOTS-1:0]          cap_en
);

   localparam int CW    = cmd_width(ADDR_W, DATA_W);
   localparam int CNT_W = $clog2(SLOTS + 1);
   localparam int SEL_W = $clog2(SLOTS);

   logic [CW-1:0]    slot_w [SLOTS];
   logic [CNT_W-1:0] cnt_q;
   logic             in_burst;
   logic [SEL_W-1:0] sel;
   logic [CW-1:0]    cur;
   logic             cur_valid;
   sbw_op_e          cur_op;
   logic             issue;
   logic             shift_phase;
   logic             raw_rd, raw_wwe, raw_lwe, raw_inv;

   for (genvar k = 0; k < SLOTS; k++) begin : g_unpack
      assign slot_w[k] = cmd_flat[k*CW +: CW];
   end

   assign in_burst  = par_mode && (cnt_q < CNT_W'(SLOTS));
   assign sel       = in_burst ? cnt_q[SEL_W-1:0] : '0;
   assign cur       = slot_w[sel];
   assign cur_valid = cur[CW-1];
   assign cur_op    = sbw_op_e'(cur[CW-2 -: 2]);
   assign issue     = in_burst && cur_valid;

   always_comb begin
      raw_rd  = 1'b0;
      raw_wwe = 1'b0;
      raw_lwe = 1'b0;
      raw_inv = 1'b0;
      if (issue) begin
         case (cur_op)
            OP_READ: raw_rd  = 1'b1;
            OP_WWR:  raw_wwe = 1'b1;
            OP_LWR:  raw_lwe = 1'b1;
            OP_INV:  raw_inv = 1'b1;
            default: raw_rd  = 1'b0;
         endcase
      end
   end

   // write enables are ANDed with the inverse of the shift phase
   assign shift_phase  = !par_mode;
   assign core_rd_en   = raw_rd  & ~shift_phase;
   assign core_word_we = raw_wwe & ~shift_phase;
   assign core_line_we = raw_lwe & ~shift_phase;
   assign core_inval   = raw_inv & ~shift_phase;
   assign core_addr    = cur[DATA_W +: ADDR_W];
   assign core_wdata   = cur[DATA_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n || shift_phase) begin
         cnt_q <= '0;
      end else if (in_burst) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   logic             pv_q   [RD_LAT];
   logic [SEL_W-1:0] pidx_q [RD_LAT];

   always_ff @(posedge clk) begin
      if (!rst_n || shift_phase) begin
         for (int s = 0; s < RD_LAT; s++) begin
            pv_q[s]   <= 1'b0;
            pidx_q[s] <= '0;
         end
      end else begin
         pv_q[0]   <= issue;
         pidx_q[0] <= sel;
         for (int s = 1; s < RD_LAT; s++) begin
            pv_q[s]   <= pv_q[s-1];
            pidx_q[s] <= pidx_q[s-1];
         end
      end
   end

   for (genvar j = 0; j < SLOTS; j++) begin : g_cap
      assign cap_en[j] = par_mode && pv_q[RD_LAT-1] &&
                         (pidx_q[RD_LAT-1] == SEL_W'(j));
   end

endmodule

// File: rtl/scan_burst_wrapper.sv
module scan_burst_wrapper
   import sbw_pkg::*;
#(
   parameter int SLOTS  = 4,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int RD_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              par_mode,
   input  logic              scan_in,
   output logic              scan_out,
   output logic              core_rd_en,
   output logic              core_word_we,
   output logic              core_line_we,
   output logic              core_inval,
   output logic [ADDR_W-1:0] core_addr,
   output logic [DATA_W-1:0] core_wdata,
   input  logic [DATA_W-1:0] core_rdata,
   input  logic              core_hit
);

   localparam int CW      = cmd_width(ADDR_W, DATA_W);
   localparam int RW      = res_width(DATA_W);
   localparam int CMD_TOT = SLOTS * CW;
   localparam int RES_TOT = SLOTS * RW;

   if (SLOTS < 2) begin : g_bad_slots
      $error("scan_burst_wrapper: SLOTS must be at least 2");
   end
   if (RD_LAT < 1 || RD_LAT > 8) begin : g_bad_lat
      $error("scan_burst_wrapper: RD_LAT must lie in 1..8");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("scan_burst_wrapper: field widths must be positive");
   end

   logic               shift_en;
   logic               cmd_to_res;
   logic [CMD_TOT-1:0] cmd_flat;
   logic [RES_TOT-1:0] res_flat;
   logic [SLOTS-1:0]   cap_en;

   assign shift_en = !par_mode;

   sbw_cmd_bank #(
      .SLOTS (SLOTS),
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_cmd (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(shift_en),
      .ser_in  (scan_in),
      .ser_out (cmd_to_res),
      .cmd_flat(cmd_flat)
   );

   sbw_issue_seq #(
      .SLOTS (SLOTS),
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .RD_LAT(RD_LAT)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .par_mode    (par_mode),
      .cmd_flat    (cmd_flat),
      .core_rd_en  (core_rd_en),
      .core_word_we(core_word_we),
      .core_line_we(core_line_we),
      .core_inval  (core_inval),
      .core_addr   (core_addr),
      .core_wdata  (core_wdata),
      .cap_en      (cap_en)
   );

   sbw_res_bank #(
      .SLOTS (SLOTS),
      .DATA_W(DATA_W)
   ) u_res (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(shift_en),
      .ser_in  (cmd_to_res),
      .cap_en  (cap_en),
      .cap_hit (core_hit),
      .cap_data(core_rdata),
      .ser_out (scan_out),
      .res_flat(res_flat)
   );

endmodule

// File: rtl/sbw_chk.sv
module sbw_chk
   import sbw_pkg::*;
#(
   parameter int SLOTS  = 4,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input logic clk,
   input logic rst_n,
   input logic par_mode,
   input logic scan_in,
   input logic scan_out,
   input logic core_rd_en,
   input logic core_word_we,
   input logic core_line_we,
   input logic core_inval,
   input logic cmd_bit0,
   input logic res_below_top,
   input logic [SLOTS*cmd_width(ADDR_W, DATA_W)-1:0] cmd_flat
);

   logic [3:0]  strobes;
   logic [15:0] issued_q;
   logic        mode_q;

   assign strobes = {core_rd_en, core_word_we, core_line_we, core_inval};

   always_ff @(posedge clk) begin
      if (!rst_n || !par_mode) begin
         issued_q <= '0;
      end else if (strobes != 4'b0000) begin
         issued_q <= issued_q + 16'd1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= 1'b0;
      else        mode_q <= par_mode;
   end

   p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !par_mode |=> (cmd_bit0 == $past(scan_in)));

   p_shift_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !par_mode |=> (scan_out == $past(res_below_top)));

   p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !par_mode |-> (strobes == 4'b0000));

   p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(strobes));

   p_burst_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      issued_q <= 16'(SLOTS));

   p_cmd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (par_mode && mode_q) |-> $stable(cmd_flat));

endmodule

bind scan_burst_wrapper sbw_chk #(
   .SLOTS (SLOTS),
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .par_mode     (par_mode),
   .scan_in      (scan_in),
   .scan_out     (scan_out),
   .core_rd_en   (core_rd_en),
   .core_word_we (core_word_we),
   .core_line_we (core_line_we),
   .core_inval   (core_inval),
   .cmd_bit0     (cmd_flat[0]),
   .res_below_top(res_flat[RES_TOT-2]),
   .cmd_flat     (cmd_flat)
);

// File: tb/scan_burst_wrapper_tb.sv
`timescale 1ns/1ps
module scan_burst_wrapper_tb;

   localparam int SLOTS   = 4;
   localparam int ADDR_W  = 3;
   localparam int DATA_W  = 8;
   localparam int CW      = 3 + ADDR_W + DATA_W;
   localparam int RW      = DATA_W + 2;
   localparam int CMD_TOT = SLOTS * CW;
   localparam int L       = SLOTS * (CW + RW);
   localparam int NB      = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic par_mode = 1'b0;
   logic scan_in = 1'b0;
   logic scan_out;
   logic core_rd_en, core_word_we, core_line_we, core_inval;
   logic [ADDR_W-1:0] core_addr;
   logic [DATA_W-1:0] core_wdata;
   logic [DATA_W-1:0] core_rdata = '0;
   logic core_hit = 1'b0;

   int vectors = 0;
   int fails = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   scan_burst_wrapper #(
      .SLOTS(SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_LAT(1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .par_mode(par_mode),
      .scan_in(scan_in), .scan_out(scan_out),
      .core_rd_en(core_rd_en), .core_word_we(core_word_we),
      .core_line_we(core_line_we), .core_inval(core_inval),
      .core_addr(core_addr), .core_wdata(core_wdata),
      .core_rdata(core_rdata), .core_hit(core_hit)
   );

   // behavioural core: one-cycle response reporting the state before the update
   logic [DATA_W-1:0] mem [1<<ADDR_W];
   logic              vld [1<<ADDR_W];
   initial for (int i = 0; i < (1<<ADDR_W); i++) begin mem[i] = '0; vld[i] = 1'b0; end

   always @(posedge clk) begin
      if (core_rd_en | core_word_we | core_line_we | core_inval) begin
         core_rdata <= mem[core_addr];
         core_hit   <= vld[core_addr];
         if (core_word_we) mem[core_addr] <= core_wdata;
         if (core_line_we) begin mem[core_addr] <= core_wdata; vld[core_addr] <= 1'b1; end
         if (core_inval)   vld[core_addr] <= 1'b0;
      end
   end

   // bench reference state
   logic [DATA_W-1:0] rm [1<<ADDR_W];
   logic              rv [1<<ADDR_W];
   logic [L-1:0]      exp_chain = '0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic logic [3:0] strobes();
      return {core_rd_en, core_word_we, core_line_we, core_inval};
   endfunction

   // shift L bits; compare unloaded stream with exp_chain slot by slot
   task automatic shift_chain(input logic [L-1:0] nv);
      logic [L-1:0] got;
      bit leak;
      got = '0;
      leak = 0;
      for (int i = 0; i < L; i++) begin
         scan_in = nv[L-1-i];
         got[L-1-i] = scan_out;
         if (strobes() != 4'b0) leak = 1;
         @(negedge clk);
      end
      check(!leak, "R2 strobes while shifting", {31'd0, leak}, 32'd0);
      for (int k = 0; k < SLOTS; k++) begin
         check(got[k*CW +: CW] == exp_chain[k*CW +: CW], "R1/R4/R7 command slot readback",
               32'(got[k*CW +: CW]), 32'(exp_chain[k*CW +: CW]));
         check(got[CMD_TOT + k*RW +: RW] == exp_chain[CMD_TOT + k*RW +: RW],
               "R5/R6/R8 result slot readback",
               32'(got[CMD_TOT + k*RW +: RW]), 32'(exp_chain[CMD_TOT + k*RW +: RW]));
      end
   endtask

   initial begin
      for (int i = 0; i < (1<<ADDR_W); i++) begin rm[i] = '0; rv[i] = 1'b0; end
      repeat (3) @(negedge clk);
      // R9: reset state
      check(scan_out == 1'b0, "R9 scan_out after reset", {31'd0, scan_out}, 32'd0);
      check(strobes() == 4'b0, "R9 strobes in reset", 32'(strobes()), 32'd0);
      rst_n = 1'b1;

      for (int b = 0; b < NB; b++) begin
         logic [L-1:0] nv;
         logic [L-1:0] next_exp;
         logic [3:0]   mask;
         logic [1:0]   op  [SLOTS];
         logic [ADDR_W-1:0] ad [SLOTS];
         logic [DATA_W-1:0] dt [SLOTS];
         mask = (b < 16) ? 4'(b) : 4'hF;
         nv = '0;
         for (int k = 0; k < SLOTS; k++) begin
            op[k] = 2'((b + k + b/4) % 4);
            ad[k] = ADDR_W'((b * 3 + k) % 5);
            dt[k] = DATA_W'(b * 16 + k * 5 + 1);
            nv[k*CW +: CW] = {mask[k], op[k], ad[k], dt[k]};
            nv[CMD_TOT + k*RW +: RW] = {1'b0, 1'(b), DATA_W'(8'hA5 ^ (b + k))};
         end
         shift_chain(nv);
         // expected after the burst: R6 for valid slots, R5 preload kept otherwise
         next_exp = nv;
         for (int k = 0; k < SLOTS; k++) begin
            if (mask[k]) begin
               next_exp[CMD_TOT + k*RW +: RW] = {1'b1, rv[ad[k]], rm[ad[k]]};
               case (op[k])
                  2'b01: rm[ad[k]] = dt[k];
                  2'b10: begin rm[ad[k]] = dt[k]; rv[ad[k]] = 1'b1; end
                  2'b11: rv[ad[k]] = 1'b0;
                  default: ;
               endcase
            end
         end
         exp_chain = next_exp;
         // burst: R3 issue order and decode, R5 empty slots
         par_mode = 1'b1;
         for (int k = 0; k < SLOTS; k++) begin
            logic [3:0] es;
            #1;
            es = mask[k] ? (4'b1000 >> op[k]) : 4'b0000;
            check(strobes() == es, "R3/R5 strobe for slot", 32'(strobes()), 32'(es));
            if (mask[k])
               check({core_addr, core_wdata} == {ad[k], dt[k]}, "R3 address/data for slot",
                     32'({core_addr, core_wdata}), 32'({ad[k], dt[k]}));
            @(negedge clk);
         end
         for (int h = 0; h < 3; h++) begin
            check(strobes() == 4'b0, "R7 idle after burst", 32'(strobes()), 32'd0);
            @(negedge clk);
         end
         par_mode = 1'b0;
      end
      shift_chain('0);

      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog: run did not finish (actual=timeout expected=end)");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule